// File: doc/BRIEF.md
# Antenna Switch Pattern Sequencer

This block holds a short list of antenna identifiers and drives them onto a bank of antenna-select outputs while a constant tone extension (CTE) follows a packet. Software appends identifiers through a push port and reads the number of stored entries back at any time. A clear strobe empties the list. A timing controller starts each CTE and supplies its length in 8 µs units, the slot spacing (2 µs or 4 µs), the direction (transmit or receive) and the angle mode (arrival or departure).

Each list position has a fixed role. Position 0 is the idle antenna, used whenever no CTE is running. Position 1 is used for the 4 µs guard and the 8 µs reference period. Positions 2 and up are used for the switch slots that follow. After the reference period, switch slots and sample slots alternate, each one spacing long. The antenna advances at the start of every switch slot and holds through the sample slot after it. When the CTE ends, the outputs go back to the idle antenna in the same cycle.

Whether switching happens at all depends on the angle mode and the direction. Arrival mode switches only on receive, and departure mode switches only on transmit. In the other two combinations the idle antenna stays selected for the whole CTE. A per-output connect mask holds unconnected outputs low.

Top module: `ant_pattern_seq`

## Requirements
- R1: Each cycle with `pat_push` high and `pat_clear` low stores `pat_data` at position `pat_count` and increments `pat_count` by one on the next clock edge.
- R2: A cycle with `pat_clear` high brings `pat_count` and `pat_overflow` to zero and ends any running CTE on the next edge. Clear takes priority over a push in the same cycle.
- R3: A push while `pat_count` equals DEPTH (default 40) is dropped, leaves `pat_count` at DEPTH and sets `pat_overflow`. The flag stays set until a clear.
- R4: While `cte_busy` is low, `ant_sel` equals position 0 ANDed with `connect_mask`.
- R5: With switching enabled, `ant_sel` shows position 1 during the first 12 µs of a CTE (4 µs guard plus 8 µs reference).
- R6: After those 12 µs, slots of 2 µs (`spacing_4us`=0) or 4 µs (`spacing_4us`=1) alternate, starting with a switch slot. The j-th switch slot (j from 0) and the sample slot after it show position 2+j.
- R7: When position 2+j is not stored, the last stored position (`pat_count`-1) is shown until the CTE ends.
- R8: A `cte_start` pulse while idle with a nonzero `cte_len` raises `cte_busy` on the next edge for exactly `cte_len`×8 µs (CYC_PER_US cycles per µs). Outputs return to position 0 in the first cycle `cte_busy` is low. A start with `cte_len`=0, or a start while busy, is ignored.
- R9: Switching is enabled when `mode_aod`=1 with `dir_tx`=1, or when `mode_aod`=0 with `dir_tx`=0. Otherwise `ant_sel` stays at position 0 for the whole CTE.
- R10: Bit n of `ant_sel` is bit n of the selected entry when `connect_mask[n]` is 1, and 0 otherwise.
- R11: A position at or beyond `pat_count` reads as all zeros, so after a reset or a clear `ant_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pat_push | input | 1 | Append `pat_data` to the list |
| pat_data | input | ANT_W | Antenna identifier to append |
| pat_clear | input | 1 | Empty the list, clear the overflow flag, abort the CTE |
| pat_count | output | $clog2(DEPTH+1) | Number of stored entries |
| pat_overflow | output | 1 | Sticky flag for dropped pushes |
| cte_start | input | 1 | Begin a CTE |
| cte_len | input | LEN_W | CTE length in 8 µs units |
| spacing_4us | input | 1 | Slot spacing: 0 = 2 µs, 1 = 4 µs |
| dir_tx | input | 1 | 1 = transmit, 0 = receive |
| mode_aod | input | 1 | 1 = departure mode, 0 = arrival mode |
| connect_mask | input | ANT_W | Per-output connect flag |
| cte_busy | output | 1 | CTE in progress |
| ant_sel | output | ANT_W | Antenna-select outputs |

## Verification
The hardest state to reach from the ports is a switch-slot index that has run past the stored list, so that the clamp to the last entry takes over. The stimulus reaches it by storing only a few entries and then starting a long CTE at 2 µs spacing. Random runs also mix list lengths against CTE lengths so that some runs end before the list is used up and others outlast it. A clear and a second start pulse are also injected in the middle of a running CTE, to show that the abort takes effect and that the restart is ignored.

// File: rtl/ant_seq_pkg.sv
package ant_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_GUARDREF = 2'd1,
        PH_SLOT     = 2'd2
    } seq_phase_e;

    localparam int GUARD_US = 4;
    localparam int REF_US   = 8;
    localparam int PRE_US   = GUARD_US + REF_US;

    typedef struct packed {
        logic sp4;
        logic sw_en;
    } cte_cfg_t;

    function automatic logic switch_allowed(input logic aod, input logic tx);
        return aod ? tx : !tx;
    endfunction

endpackage

// File: rtl/ant_pat_buf.sv
module ant_pat_buf #(
    parameter int DEPTH = 40,
    parameter int ANT_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [ANT_W-1:0] push_data,
    input  logic             clear,
    input  logic [CNT_W-1:0] rd_idx,
    output logic [ANT_W-1:0] rd_data,
    output logic [ANT_W-1:0] entry0,
    output logic [CNT_W-1:0] count,
    output logic             overflow
);
    logic [ANT_W-1:0] mem [DEPTH];
    logic             full;

    assign full = (count == CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count    <= '0;
            overflow <= 1'b0;
        end else if (push) begin
            if (full) overflow <= 1'b1;
            else      count    <= count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && !clear && push && !full)
            mem[count[IDX_W-1:0]] <= push_data;
    end

    assign entry0  = (count != '0) ? mem[0] : '0;
    assign rd_data = (rd_idx < count) ? mem[rd_idx[IDX_W-1:0]] : '0;

    // R1
    push_advance_chk: assert property (@(posedge clk) disable iff (rst)
        push && !clear && !full |=> count == $past(count) + CNT_W'(1));
    // R2
    clear_empty_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> count == '0 && !overflow);
    // R3
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        push && !clear && full |=> full && overflow);
    // R3
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overflow && !clear |=> overflow);
    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

endmodule

// File: rtl/ant_phase_timer.sv
module ant_phase_timer
    import ant_seq_pkg::*;
#(
    parameter int CYC_PER_US = 4,
    parameter int LEN_W = 5,
    localparam int US_W  = LEN_W + 3,
    localparam int DIV_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    input  cte_cfg_t         cfg_in,
    output logic             busy,
    output seq_phase_e       phase,
    output logic             sw_en,
    output logic [US_W-1:0]  slot_no
);
    logic [DIV_W-1:0] div_q;
    logic [US_W-1:0]  us_q;
    logic [LEN_W-1:0] len_q;
    cte_cfg_t         cfg_q;
    logic             us_tick;
    logic             last;
    logic [US_W-1:0]  rel;
    logic [US_W-1:0]  half;

    assign us_tick = (div_q == DIV_W'(CYC_PER_US - 1));
    assign last    = busy && us_tick && (us_q == ({len_q, 3'b000} - US_W'(1)));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            busy  <= 1'b0;
            div_q <= '0;
            us_q  <= '0;
            len_q <= '0;
            cfg_q <= '0;
        end else if (!busy) begin
            if (start && len != '0) begin
                busy  <= 1'b1;
                div_q <= '0;
                us_q  <= '0;
                len_q <= len;
                cfg_q <= cfg_in;
            end
        end else if (us_tick) begin
            div_q <= '0;
            if (last) busy <= 1'b0;
            else      us_q <= us_q + US_W'(1);
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    always_comb begin
        if (!busy)                      phase = PH_IDLE;
        else if (us_q < US_W'(PRE_US))  phase = PH_GUARDREF;
        else                            phase = PH_SLOT;
        rel     = us_q - US_W'(PRE_US);
        half    = cfg_q.sp4 ? (rel >> 2) : (rel >> 1);
        slot_no = half >> 1;
        sw_en   = cfg_q.sw_en;
    end

    // R8
    zero_len_chk: assert property (@(posedge clk) disable iff (rst)
        start && !busy && len == '0 && !clear |=> !busy);
    // R8
    start_go_chk: assert property (@(posedge clk) disable iff (rst)
        start && !busy && len != '0 && !clear |=> busy && us_q == '0);
    // R8
    hold_len_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !clear && !last |=> busy && $stable(len_q));

endmodule

// File: rtl/ant_out_drive.sv
module ant_out_drive
    import ant_seq_pkg::*;
#(
    parameter int ANT_W = 8,
    parameter int CNT_W = 6,
    parameter int US_W  = 8,
    localparam int IW   = ((US_W + 1) > CNT_W) ? (US_W + 1) : CNT_W
) (
    input  seq_phase_e       phase,
    input  logic             sw_en,
    input  logic [US_W-1:0]  slot_no,
    input  logic [CNT_W-1:0] count,
    input  logic [ANT_W-1:0] entry0,
    input  logic [ANT_W-1:0] rd_data,
    input  logic [ANT_W-1:0] mask,
    output logic [CNT_W-1:0] rd_idx,
    output logic [ANT_W-1:0] ant_sel
);
    logic [IW-1:0]    raw;
    logic [IW-1:0]    cnt_w;
    logic [IW-1:0]    pick;
    logic [ANT_W-1:0] chosen;

    always_comb begin
        raw   = IW'(slot_no) + IW'(2);
        cnt_w = IW'(count);
        pick  = (raw >= cnt_w) ? (cnt_w - IW'(1)) : raw;
        case (phase)
            PH_GUARDREF: rd_idx = CNT_W'(1);
            PH_SLOT:     rd_idx = pick[CNT_W-1:0];
            default:     rd_idx = '0;
        endcase
        chosen  = (phase == PH_IDLE || !sw_en) ? entry0 : rd_data;
        ant_sel = chosen & mask;
    end

endmodule

// File: rtl/ant_pattern_seq.sv
module ant_pattern_seq
    import ant_seq_pkg::*;
#(
    parameter int DEPTH      = 40,
    parameter int ANT_W      = 8,
    parameter int LEN_W      = 5,
    parameter int CYC_PER_US = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int US_W  = LEN_W + 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pat_push,
    input  logic [ANT_W-1:0] pat_data,
    input  logic             pat_clear,
    output logic [CNT_W-1:0] pat_count,
    output logic             pat_overflow,
    input  logic             cte_start,
    input  logic [LEN_W-1:0] cte_len,
    input  logic             spacing_4us,
    input  logic             dir_tx,
    input  logic             mode_aod,
    input  logic [ANT_W-1:0] connect_mask,
    output logic             cte_busy,
    output logic [ANT_W-1:0] ant_sel
);
    cte_cfg_t         cfg_in;
    seq_phase_e       phase;
    logic             sw_en;
    logic [US_W-1:0]  slot_no;
    logic [CNT_W-1:0] rd_idx;
    logic [ANT_W-1:0] rd_data;
    logic [ANT_W-1:0] entry0;

    assign cfg_in.sp4   = spacing_4us;
    assign cfg_in.sw_en = switch_allowed(mode_aod, dir_tx);

    ant_pat_buf #(.DEPTH(DEPTH), .ANT_W(ANT_W)) buf_i (
        .clk(clk), .rst(rst), .push(pat_push), .push_data(pat_data),
        .clear(pat_clear), .rd_idx(rd_idx), .rd_data(rd_data),
        .entry0(entry0), .count(pat_count), .overflow(pat_overflow)
    );

    ant_phase_timer #(.CYC_PER_US(CYC_PER_US), .LEN_W(LEN_W)) tmr_i (
        .clk(clk), .rst(rst), .clear(pat_clear), .start(cte_start),
        .len(cte_len), .cfg_in(cfg_in), .busy(cte_busy), .phase(phase),
        .sw_en(sw_en), .slot_no(slot_no)
    );

    ant_out_drive #(.ANT_W(ANT_W), .CNT_W(CNT_W), .US_W(US_W)) drv_i (
        .phase(phase), .sw_en(sw_en), .slot_no(slot_no), .count(pat_count),
        .entry0(entry0), .rd_data(rd_data), .mask(connect_mask),
        .rd_idx(rd_idx), .ant_sel(ant_sel)
    );

    // R8
    end_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cte_busy && !pat_clear |=> cte_busy || ant_sel == (entry0 & connect_mask));

endmodule

// File: tb/ant_pattern_seq_tb_top.sv
module ant_pattern_seq_tb_top;
    localparam int DEPTH = 40;
    localparam int ANT_W = 8;
    localparam int LEN_W = 5;
    localparam int CYC   = 4;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic clk = 0, rst = 1;
    logic pat_push = 0, pat_clear = 0, cte_start = 0;
    logic [ANT_W-1:0] pat_data = '0, connect_mask = '1;
    logic [CNT_W-1:0] pat_count;
    logic pat_overflow, cte_busy;
    logic [LEN_W-1:0] cte_len = '0;
    logic spacing_4us = 0, dir_tx = 1, mode_aod = 1;
    logic [ANT_W-1:0] ant_sel;

    int tests = 0, fails = 0;
    bit done = 0;
    logic [ANT_W-1:0] mb [64];
    int mcnt = 0;
    bit movf = 0;

    always #4 clk = ~clk;

    ant_pattern_seq #(.DEPTH(DEPTH), .ANT_W(ANT_W), .LEN_W(LEN_W), .CYC_PER_US(CYC)) dut_i (
        .clk(clk), .rst(rst), .pat_push(pat_push), .pat_data(pat_data),
        .pat_clear(pat_clear), .pat_count(pat_count), .pat_overflow(pat_overflow),
        .cte_start(cte_start), .cte_len(cte_len), .spacing_4us(spacing_4us),
        .dir_tx(dir_tx), .mode_aod(mode_aod), .connect_mask(connect_mask),
        .cte_busy(cte_busy), .ant_sel(ant_sel)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int ment(input int idx);
        return (idx < mcnt) ? int'(mb[idx]) : 0;
    endfunction

    task automatic push1(input logic [ANT_W-1:0] v);
        pat_push = 1; pat_data = v;
        @(negedge clk);
        pat_push = 0;
        if (mcnt < DEPTH) begin mb[mcnt] = v; mcnt++; end
        else movf = 1;
    endtask

    task automatic clear1();
        pat_clear = 1;
        @(negedge clk);
        pat_clear = 0;
        mcnt = 0; movf = 0;
    endtask

    task automatic check_store(input string tag);
        check(int'(pat_count) == mcnt, tag, int'(pat_count), mcnt);
        check(pat_overflow == movf, tag, int'(pat_overflow), int'(movf));
    endtask

    // expected output e cycles after the start edge
    task automatic check_cte(input int e, input int total, input bit sp4, input bit sw,
                             input bit aborted);
        int exp, us, idx;
        string tag;
        bit busy_e;
        busy_e = !aborted && e < total;
        if (!busy_e) begin exp = ment(0); tag = "R4/R8"; end
        else if (!sw) begin exp = ment(0); tag = "R9"; end
        else begin
            us = e / CYC;
            if (us < 12) begin exp = ment(1); tag = "R5"; end
            else begin
                idx = 2 + ((sp4 ? (us - 12) / 4 : (us - 12) / 2) / 2);
                tag = "R6";
                if (idx >= mcnt) begin idx = mcnt - 1; tag = "R7"; end
                exp = (idx < 0) ? 0 : ment(idx);
            end
        end
        exp = exp & int'(connect_mask); // R10
        check(int'(ant_sel) == exp, tag, int'(ant_sel), exp);
        check(cte_busy == busy_e, "R8 busy", int'(cte_busy), int'(busy_e));
    endtask

    task automatic run_cte(input int len, input bit sp4, input bit tx, input bit aod,
                           input int restart_at, input int clear_at);
        int total;
        bit sw, aborted;
        total = len * 8 * CYC;
        sw = aod ? tx : !tx;
        aborted = 0;
        cte_len = LEN_W'(len); spacing_4us = sp4; dir_tx = tx; mode_aod = aod;
        cte_start = 1;
        @(negedge clk);
        cte_start = 0;
        for (int e = 0; e <= total + 1; e++) begin
            check_cte(e, total, sp4, sw, aborted);
            if (e == restart_at) begin
                cte_start = 1; cte_len = 1; spacing_4us = !sp4;
                @(negedge clk);
                cte_start = 0; spacing_4us = sp4;
            end else if (e == clear_at) begin
                clear1();
                aborted = 1;
            end else begin
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11 reset state
        check_store("R11 reset");
        check(ant_sel == '0, "R11 reset out", int'(ant_sel), 0);
        check(cte_busy == 0, "R8 reset busy", int'(cte_busy), 0);

        // R1 directed pushes
        for (int i = 0; i < 6; i++) begin
            push1(ANT_W'(8'h11 * (i + 1)));
            check_store("R1");
        end
        check(int'(ant_sel) == ment(0), "R4 idle", int'(ant_sel), ment(0));

        run_cte(3, 0, 1, 1, -1, -1);   // R6 departure tx, 2us
        run_cte(4, 1, 1, 1, -1, -1);   // R6 4us
        run_cte(10, 0, 0, 0, -1, -1);  // R7 arrival rx, list exhausted
        run_cte(2, 0, 1, 0, -1, -1);   // R9 arrival tx: no switching
        run_cte(2, 1, 0, 1, -1, -1);   // R9 departure rx: no switching
        connect_mask = 8'h5A;
        run_cte(3, 0, 1, 1, 20, -1);   // R10 mask, R8 restart ignored

        // R8 zero-length start ignored
        cte_len = 0; cte_start = 1;
        @(negedge clk);
        cte_start = 0;
        check(cte_busy == 0, "R8 len0", int'(cte_busy), 0);

        // R2 clear in mid-CTE
        connect_mask = '1;
        run_cte(3, 0, 1, 1, -1, 57);
        check_store("R2 clear");
        check(ant_sel == '0, "R11 after clear", int'(ant_sel), 0);

        // R2 clear beats push
        pat_push = 1; pat_clear = 1; pat_data = 8'hAB;
        @(negedge clk);
        pat_push = 0; pat_clear = 0;
        check_store("R2 clear priority");

        // R3 overflow
        for (int i = 0; i < DEPTH + 3; i++) push1(ANT_W'($urandom));
        check_store("R3 full");
        repeat (5) @(negedge clk);
        check_store("R3 sticky");
        run_cte(31, 0, 0, 0, -1, -1);  // R6/R7 on full list
        clear1();
        check_store("R3 cleared");

        // random runs
        for (int it = 0; it < 20; it++) begin
            int n;
            clear1();
            n = 1 + int'($urandom % 45);
            for (int i = 0; i < n; i++) push1(ANT_W'($urandom));
            check_store("R1/R3 random");
            connect_mask = ANT_W'($urandom);
            run_cte(1 + int'($urandom % 12), 1'($urandom), 1'($urandom), 1'($urandom), -1, -1);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule